// File: doc/BRIEF.md
# Serial Port Register and Flag Interface

This block is the bus-facing side of a simple serial port. A processor reaches it through a memory-mapped port. The port has separate read and write strobes, a byte address and 32-bit data. The block holds one status word, the last received byte, a baud setting, three control words and a guard-time word. Only the status word and the first control word affect behaviour. The baud, guard-time and the other two control words are stored and read back.

Toward the line side the block works in whole bytes. A write to the data offset launches a byte as a single-cycle transmit strobe. There is no back-pressure on this side. Incoming bytes arrive over a valid/ready pair. Ready is high exactly while the receive-full flag is clear. A byte transfers on a cycle where valid and ready are both high. The sender must hold valid and the byte until that cycle. While ready is low the block takes nothing, and the byte already held is not overwritten.

Reads and writes have side effects on the flags, and one level interrupt reports received data. Read data is combinational. It is valid in the same cycle as the read strobe, and the side effects of the read take hold at the next clock edge. A cycle with both strobes high is treated as a write only.

Top module: `serport_regs`

## Requirements
- R1: After reset the status word is 0x0000_00C0, every other register reads zero, `irq` and `tx_valid` are low, and `rx_ready` is high.
- R2: `rx_ready` equals the inverse of the receive-full flag (status bit 5). A byte is taken only on a cycle with `rx_valid` and `rx_ready` both high.
- R3: Every byte that is taken is stored, and the data offset (0x04) reads it back. Control word 1 is at 0x0C, with unit enable at bit 13 and receive enable at bit 2. When either enable bit is clear, a byte that is taken sets no flag and leaves `irq` unchanged.
- R4: When both enable bits are set, a byte that is taken sets the receive-full flag at the next edge. If the receive-interrupt enable (control word 1, bit 5) is also set, `irq` goes high at that edge.
- R5: A read of the status word (0x00) returns its value before the read, and the transmit-complete flag (bit 6) is clear after that edge.
- R6: A read at 0x04 returns the stored byte masked to its low 10 bits. After that edge the transmit-empty flag (bit 7) is set, the receive-full flag is clear and `irq` is low.
- R7: A status write with a value of at most 0x3FF replaces the word. A larger value is ANDed into it. After either write, `irq` is low if the receive-full flag is clear.
- R8: A write at 0x04 with a value below 0xF000 gives, at the next edge, a one-cycle `tx_valid` carrying the low 8 bits, sets transmit-complete and clears transmit-empty. A value of 0xF000 or more gives no pulse and changes no flag.
- R9: A write to control word 1 with bit 5 set, made while the receive-full flag is already set, raises `irq` at the next edge.
- R10: The baud (0x08), control 1 (0x0C), control 2 (0x10), control 3 (0x14) and guard-time (0x18) words store all 32 written bits and read them back.
- R11: Any other address reads as zero, and a write to it changes no register.
- R12: When a byte that sets the receive-full flag is taken in the same cycle as a bus access that would clear that flag, the flag ends set.
- R13: `irq` is high only while the receive-full flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 13 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit, valid with `tx_valid` |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Block can accept a received byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the two bus strobes are never high together. Under that assumption, a status-read or data-read cycle carries no other bus operation that could touch the same flags. The stimulus keeps to this rule. Each random cycle issues a read, a write or nothing, never both. The receive side offers a byte on about half the cycles regardless of `rx_ready`, so bytes offered while the block is full are also exercised. Control values are biased toward setting the enable bits, so the interrupt and receive-full paths are reached often.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int NCFG   = 5;

  localparam logic [REG_W-1:0] OFF_STAT = 32'h00;
  localparam logic [REG_W-1:0] OFF_DATA = 32'h04;
  localparam logic [REG_W-1:0] OFF_CFG0 = 32'h08;

  // stored-only and control words, in address order from OFF_CFG0
  localparam int CFG_BAUD  = 0;
  localparam int CFG_CTL1  = 1;
  localparam int CFG_CTL2  = 2;
  localparam int CFG_CTL3  = 3;
  localparam int CFG_GUARD = 4;

  localparam int ST_TXE  = 7;
  localparam int ST_TC   = 6;
  localparam int ST_RXNE = 5;
  localparam logic [REG_W-1:0] ST_RESET = 32'h0000_00C0;

  localparam int C1_EN   = 13;
  localparam int C1_RXIE = 5;
  localparam int C1_RXEN = 2;

  localparam logic [REG_W-1:0] ST_REPLACE_MAX = 32'h0000_03FF;
  localparam logic [REG_W-1:0] TX_LIMIT       = 32'h0000_F000;
  localparam logic [REG_W-1:0] RD_MASK        = 32'h0000_03FF;

  function automatic logic [REG_W-1:0] cfg_offset(input int idx);
    return OFF_CFG0 + REG_W'(4 * idx);
  endfunction
endpackage

// File: rtl/serport_decode.sv
module serport_decode
  import serport_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_stat,
  output logic              hit_data,
  output logic [NCFG-1:0]   hit_cfg
);
  assign hit_stat = (addr == ADDR_W'(OFF_STAT));
  assign hit_data = (addr == ADDR_W'(OFF_DATA));

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    assign hit_cfg[i] = (addr == ADDR_W'(cfg_offset(i)));
  end
endmodule

// File: rtl/serport_cfgreg.sv
module serport_cfgreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/serport_txstrobe.sv
module serport_txstrobe
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [REG_W-1:0]  wdata,
  output logic              tx_go,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);
  assign tx_go = data_wr && (wdata < TX_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= tx_go;
      if (tx_go) tx_byte <= wdata[BYTE_W-1:0];
    end
  end

  assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && wdata < TX_LIMIT) |=> (tx_valid && tx_byte == $past(wdata[BYTE_W-1:0])));

  assert_tx_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && wdata < TX_LIMIT) |=> !tx_valid);
endmodule

// File: rtl/serport_flags.sv
module serport_flags
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic              data_rd,
  input  logic              ctl1_wr,
  input  logic              tx_go,
  input  logic [REG_W-1:0]  wdata,
  input  logic              en_unit,
  input  logic              en_rx,
  input  logic              en_rxie,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic [REG_W-1:0]  stat_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              irq
);
  logic [REG_W-1:0] stat_n;
  logic             irq_n;
  logic             rx_fire, rx_arm;

  assign rx_ready = ~stat_q[ST_RXNE];
  assign rx_fire  = rx_valid & rx_ready;
  assign rx_arm   = rx_fire & en_unit & en_rx;

  // later lines win: a received byte has the last word on RXNE
  always_comb begin
    stat_n = stat_q;
    if (stat_rd) stat_n[ST_TC] = 1'b0;
    if (data_rd) begin
      stat_n[ST_TXE]  = 1'b1;
      stat_n[ST_RXNE] = 1'b0;
    end
    if (stat_wr) stat_n = (wdata <= ST_REPLACE_MAX) ? wdata : (stat_q & wdata);
    if (tx_go) begin
      stat_n[ST_TC]  = 1'b1;
      stat_n[ST_TXE] = 1'b0;
    end
    if (rx_arm) stat_n[ST_RXNE] = 1'b1;
  end

  always_comb begin
    irq_n = irq;
    if (data_rd)                                       irq_n = 1'b0;
    if (stat_wr && !stat_n[ST_RXNE])                   irq_n = 1'b0;
    if (ctl1_wr && wdata[C1_RXIE] && stat_q[ST_RXNE])  irq_n = 1'b1;
    if (rx_arm && en_rxie)                             irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= ST_RESET;
      data_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_n;
      irq    <= irq_n;
      if (rx_fire) data_q <= rx_byte;
    end
  end

  assert_rx_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && en_unit && en_rx) |=> stat_q[ST_RXNE]);

  assert_rx_raises_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && en_unit && en_rx && en_rxie) |=> irq);

  assert_rx_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (data_q == $past(rx_byte)));

  assert_disabled_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !(en_unit && en_rx) && !stat_wr) |=> !stat_q[ST_RXNE]);

  assert_stat_read_clears_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !stat_q[ST_TC]);

  assert_data_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !(rx_valid && rx_ready)) |=> (!irq && stat_q[ST_TXE] && !stat_q[ST_RXNE]));

  assert_irq_needs_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_q[ST_RXNE]);
endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              irq
);
  logic             hit_stat, hit_data;
  logic [NCFG-1:0]  hit_cfg;
  logic             rd_ok;
  logic             tx_go;
  logic [REG_W-1:0] stat_q;
  logic [BYTE_W-1:0] data_q;
  logic [REG_W-1:0] cfg_q [NCFG];

  assign rd_ok = bus_rd & ~bus_wr;

  serport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit_stat(hit_stat), .hit_data(hit_data), .hit_cfg(hit_cfg)
  );

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    serport_cfgreg #(.W(REG_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(bus_wr & hit_cfg[i]),
      .wdata(bus_wdata), .q(cfg_q[i])
    );
  end

  serport_txstrobe u_tx (
    .clk(clk), .rst_n(rst_n), .data_wr(bus_wr & hit_data), .wdata(bus_wdata),
    .tx_go(tx_go), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  serport_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .stat_rd(rd_ok & hit_stat), .stat_wr(bus_wr & hit_stat),
    .data_rd(rd_ok & hit_data), .ctl1_wr(bus_wr & hit_cfg[CFG_CTL1]),
    .tx_go(tx_go), .wdata(bus_wdata),
    .en_unit(cfg_q[CFG_CTL1][C1_EN]), .en_rx(cfg_q[CFG_CTL1][C1_RXEN]),
    .en_rxie(cfg_q[CFG_CTL1][C1_RXIE]),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .stat_q(stat_q), .data_q(data_q), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      if (hit_stat) bus_rdata = stat_q;
      if (hit_data) bus_rdata = REG_W'(data_q) & RD_MASK;
      for (int i = 0; i < NCFG; i++)
        if (hit_cfg[i]) bus_rdata = cfg_q[i];
    end
  end

  assert_ctl1_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cfg[CFG_CTL1] && bus_wdata[C1_RXIE] && !rx_ready) |=> irq);

  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !hit_stat && !hit_data && hit_cfg == '0) |-> bus_rdata == '0);
endmodule

// File: tb/sim_serport_regs.sv
module sim_serport_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 0, bus_wr = 0, rx_valid = 0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  rx_byte = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, rx_ready, irq;
  logic [7:0]  tx_byte;

  int checks = 0, errors = 0;
  logic [31:0] m_sr = 32'hC0;
  logic [7:0]  m_dr = '0;
  logic [31:0] m_cfg [5] = '{default: '0};
  logic        m_irq = 1'b0;

  localparam logic [31:0] C1_ALL = 32'h2024;  // unit enable 13, rx irq 5, rx enable 2

  always #2 clk = ~clk;  // 250 MHz

  serport_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [12:0] a);
    if (a == 13'h0) return m_sr;
    if (a == 13'h4) return {24'h0, m_dr} & 32'h3FF;
    if (a >= 13'h8 && a <= 13'h18 && a[1:0] == 2'b00) return m_cfg[(a - 13'h8) >> 2];
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic rd, input logic [12:0] a);
    if (a == 13'h0) return rd ? "R5" : "R7";
    if (a == 13'h4) return rd ? "R6" : "R8";
    if (a >= 13'h8 && a <= 13'h18 && a[1:0] == 2'b00) return "R10";
    return "R11";
  endfunction

  task automatic step(input logic rd, input logic wr, input logic [12:0] a,
                      input logic [31:0] d, input logic rxv, input logic [7:0] rb,
                      input string tag);
    logic fire, arm, txv, ctl1w;
    logic [31:0] sr_n;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; rx_valid = rxv; rx_byte = rb;
    #1;
    if (rd && !wr) chk(tag, bus_rdata, exp_read(a));
    chk("R2 ready", {31'b0, rx_ready}, {31'b0, ~m_sr[5]});
    fire  = rxv && !m_sr[5];
    arm   = fire && m_cfg[1][13] && m_cfg[1][2];
    txv   = wr && a == 13'h4 && d < 32'hF000;
    ctl1w = wr && a == 13'hC;
    sr_n = m_sr;
    if (rd && !wr && a == 13'h0) sr_n[6] = 1'b0;
    if (rd && !wr && a == 13'h4) begin sr_n[7] = 1'b1; sr_n[5] = 1'b0; m_irq = 1'b0; end
    if (wr && a == 13'h0) sr_n = (d <= 32'h3FF) ? d : (m_sr & d);
    if (txv) begin sr_n[6] = 1'b1; sr_n[7] = 1'b0; end
    if (arm) sr_n[5] = 1'b1;
    if (wr && a == 13'h0 && !sr_n[5]) m_irq = 1'b0;
    if (ctl1w && d[5] && m_sr[5]) m_irq = 1'b1;
    if (arm && m_cfg[1][5]) m_irq = 1'b1;
    if (fire) m_dr = rb;
    if (wr && a >= 13'h8 && a <= 13'h18 && a[1:0] == 2'b00) m_cfg[(a - 13'h8) >> 2] = d;
    m_sr = sr_n;
    @(posedge clk); #1;
    chk({tag, " irq R13"}, {31'b0, irq}, {31'b0, m_irq});
    chk("R8 tx_valid", {31'b0, tx_valid}, {31'b0, txv});
    if (txv) chk("R8 tx_byte", {24'b0, tx_byte}, {24'b0, d[7:0]});
  endtask

  task automatic rd_reg(input logic [12:0] a, input string tag);
    step(1, 0, a, 0, 0, 0, tag);
  endtask
  task automatic wr_reg(input logic [12:0] a, input logic [31:0] d, input string tag);
    step(0, 1, a, d, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int unsigned seed_set;
    seed_set = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) rd_reg(13'(k * 4), "R1");

    // R3: receiver disabled, byte still stored, no flag
    step(0, 0, 0, 0, 1, 8'h5A, "R3");
    chk("R3 ready", {31'b0, rx_ready}, 1);
    rd_reg(13'h4, "R3");
    rd_reg(13'h0, "R3");

    // R4 / R2: enabled receive with interrupt, then back-pressure
    wr_reg(13'hC, C1_ALL, "R10");
    step(0, 0, 0, 0, 1, 8'hA5, "R4");
    chk("R4 irq", {31'b0, irq}, 1);
    step(0, 0, 0, 0, 1, 8'h11, "R2");
    rd_reg(13'h4, "R6");
    chk("R6 irq", {31'b0, irq}, 0);

    // R9: late interrupt enable
    wr_reg(13'hC, 32'h2004, "R9");
    step(0, 0, 0, 0, 1, 8'h33, "R9");
    chk("R9 irq before", {31'b0, irq}, 0);
    wr_reg(13'hC, C1_ALL, "R9");
    chk("R9 irq after", {31'b0, irq}, 1);

    // R7: AND write clears RXNE and irq; replace writes
    wr_reg(13'h0, 32'hFFFF_FFDF, "R7");
    chk("R7 irq", {31'b0, irq}, 0);
    rd_reg(13'h0, "R7");
    wr_reg(13'h0, 32'h0000_02A0, "R7");
    rd_reg(13'h0, "R7");
    wr_reg(13'h0, 32'h0, "R7");

    // R8 / R5: transmit, TC read-clear, ignored large value
    wr_reg(13'h4, 32'h0000_1234, "R8");
    rd_reg(13'h0, "R5");
    rd_reg(13'h0, "R5");
    wr_reg(13'h4, 32'h0000_F000, "R8");
    rd_reg(13'h0, "R8");

    // R12: receive wins over status write and over data read
    step(0, 1, 13'h0, 32'h0, 1, 8'h77, "R12");
    rd_reg(13'h0, "R12");
    rd_reg(13'h4, "R12");
    step(1, 0, 13'h4, 0, 1, 8'h99, "R12");
    rd_reg(13'h0, "R12");
    rd_reg(13'h4, "R12");

    // R11: unmapped
    wr_reg(13'h1C, 32'hDEAD_BEEF, "R11");
    rd_reg(13'h1C, "R11");
    rd_reg(13'h40, "R11");
    rd_reg(13'h6, "R11");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned op, k, dsel;
      logic [12:0] a;
      logic [31:0] d;
      op = $urandom % 3; k = $urandom % 9; dsel = $urandom % 4;
      a = (k < 8) ? 13'(k * 4) : 13'($urandom % 8192);
      case (dsel)
        0: d = $urandom & 32'h3FF;
        1: d = $urandom;
        2: d = ($urandom & 32'h24) | 32'h2004;
        default: d = $urandom & 32'hFFFF;
      endcase
      step(op == 0, op == 1, a, d, 1'($urandom % 2), 8'($urandom), tag_of(op == 0, a));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule